// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space requester and the two places a configuration register can live: the root port's own register file, and a remote configuration window that reaches devices further down the hierarchy. Each request carries a bus, device and function number, a register offset, an access size and a read/write flag. The block first screens the bus/device/function tuple against a fixed, restricted topology. It then routes the access to local or remote space and supplies the outbound window type code and the target value that programs the window.

The downstream side only moves full, dword-aligned words. Byte and halfword reads pick the addressed lane out of the returned dword. Byte and halfword writes are done as a read of the enclosing dword, a merge of the new bytes, and a write-back of the whole dword. Requests and responses use valid/ready handshakes, and only one access is in flight at a time.

Top module: `cfg_xlate`

## Requirements
- R1: A tuple is absent when the bus is 0 and the device is greater than 1, or when the bus is 1 and the device is greater than 0. Every other tuple is present.
- R2: A read of an absent tuple responds with `rsp_rdata` = 0xFFFFFFFF and `rsp_err` = 0, whatever the size, and starts no downstream access.
- R3: A write to an absent tuple responds with `rsp_err` = 1 and `rsp_rdata` = 0, and starts no downstream access.
- R4: Bus 0 accesses have `acc_remote` = 0 and `acc_tgt` = 0. Accesses to any other bus have `acc_remote` = 1.
- R5: `acc_wtype` is 4 when the bus is 0 or 1, and 5 when the bus is 2 or more.
- R6: For a non-zero bus, `acc_tgt` holds the bus in bits 31:24, the device in bits 23:19, the function in bits 18:16, and zeros elsewhere.
- R7: `acc_addr` equals the request offset with bits 1:0 forced to zero.
- R8: Size encoding is 0 for a byte, 1 for a halfword, and 2 or 3 for a dword. A byte uses lane offset[1:0] and a halfword uses lanes {offset[1],0} and {offset[1],1}. A byte or halfword write to a present tuple makes one downstream read of the dword, then one downstream write of that dword with only the addressed lanes replaced by the low bytes of `req_wdata`.
- R9: A dword write makes exactly one downstream write carrying `req_wdata`. A dword read returns the full downstream dword. Both respond with `rsp_err` = 0.
- R10: A byte or halfword read returns the addressed lane of the downstream dword, zero-extended to 32 bits. The lanes are the ones given in R8.
- R11: `req_ready` is high only when no access is in flight. `acc_valid` and `rsp_valid`, together with their payloads, stay stable until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_bus | input | BUS_W | Bus number |
| req_dev | input | DEV_W | Device number |
| req_fn | input | FN_W | Function number |
| req_ofs | input | OFS_W | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 dword |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| acc_valid | output | 1 | Downstream access present |
| acc_ready | input | 1 | Downstream access completes |
| acc_write | output | 1 | Downstream access is a write |
| acc_remote | output | 1 | 0 local register space, 1 remote window |
| acc_wtype | output | 3 | Window type code (4 or 5) |
| acc_tgt | output | 32 | Window target value |
| acc_addr | output | OFS_W | Dword-aligned offset |
| acc_wdata | output | 32 | Full dword to write |
| acc_rdata | input | 32 | Dword read, valid with acc_ready |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Write rejected |

## Verification
The hardest case to reach is a sub-dword write whose downstream read completes, followed by a write-back that the target then stalls. The merge must use the dword captured during the read, while the write payload stays unchanged across the stall. The bench target keeps its own memory and inserts a varying wait before each ready. It issues byte writes into all four lanes and halfword writes at odd offsets into the same dword, then reads the dword back, so a merge on the wrong lane or on stale data shows up as a wrong word. Absent tuples on buses 0 and 1 are mixed into the same stream so the filter's silence downstream is checked against live traffic.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  localparam int unsigned DW = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [2:0] WT_CFG0 = 3'd4;
  localparam logic [2:0] WT_CFG1 = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RMW,
    ST_ACC,
    ST_RESP
  } state_e;

  // first byte lane touched by an access of the given size
  function automatic logic [1:0] lane_base(logic [1:0] size, logic [1:0] lo);
    case (size)
      SZ_BYTE: return lo;
      SZ_HALF: return {lo[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(logic [1:0] size, logic [1:0] lo);
    case (size)
      SZ_BYTE: return 4'b0001 << lo;
      SZ_HALF: return 4'b0011 << {lo[1], 1'b0};
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DW-1:0] merge_lanes(logic [DW-1:0] old, logic [DW-1:0] wd,
                                                logic [1:0] size, logic [1:0] lo);
    logic [DW-1:0] sh;
    logic [3:0]    m;
    logic [DW-1:0] res;
    sh = wd << {lane_base(size, lo), 3'b000};
    m  = lane_mask(size, lo);
    for (int i = 0; i < 4; i++)
      res[8*i +: 8] = m[i] ? sh[8*i +: 8] : old[8*i +: 8];
    return res;
  endfunction

  function automatic logic [DW-1:0] pick_lane(logic [DW-1:0] dw, logic [1:0] size,
                                              logic [1:0] lo);
    logic [DW-1:0] sh;
    sh = dw >> {lane_base(size, lo), 3'b000};
    case (size)
      SZ_BYTE: return {24'h0, sh[7:0]};
      SZ_HALF: return {16'h0, sh[15:0]};
      default: return dw;
    endcase
  endfunction

endpackage

// File: rtl/cfg_xlate_route.sv
module cfg_xlate_route
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned DEV_W     = 5,
  parameter int unsigned FN_W      = 3,
  parameter int unsigned OFS_W     = 12,
  parameter int unsigned BUS0_DEVS = 2,
  parameter int unsigned BUS1_DEVS = 1
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [OFS_W-1:0] ofs,
  output logic             tuple_ok,
  output logic             remote,
  output logic [2:0]       wtype,
  output logic [DW-1:0]    tgt,
  output logic [OFS_W-1:0] addr
);
  localparam int unsigned FN_LSB  = 16;
  localparam int unsigned DEV_LSB = FN_LSB + FN_W;
  localparam int unsigned BUS_LSB = DEV_LSB + DEV_W;

  logic bus_is0, bus_is1;
  assign bus_is0 = (bus == BUS_W'(0));
  assign bus_is1 = (bus == BUS_W'(1));

  always_comb begin
    tuple_ok = 1'b1;
    if (bus_is0 && (32'(dev) >= BUS0_DEVS)) tuple_ok = 1'b0;
    if (bus_is1 && (32'(dev) >= BUS1_DEVS)) tuple_ok = 1'b0;
  end

  assign remote = !bus_is0;
  assign wtype  = (bus_is0 || bus_is1) ? WT_CFG0 : WT_CFG1;
  assign addr   = {ofs[OFS_W-1:2], 2'b00};

  always_comb begin
    tgt = '0;
    if (remote) begin
      tgt[BUS_LSB +: BUS_W] = bus;
      tgt[DEV_LSB +: DEV_W] = dev;
      tgt[FN_LSB  +: FN_W]  = fn;
    end
  end
endmodule

// File: rtl/cfg_xlate_lanes.sv
module cfg_xlate_lanes
  import cfg_xlate_pkg::*;
(
  input  logic [DW-1:0] old_dw,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rd_dw,
  input  logic [1:0]    size,
  input  logic [1:0]    lo,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] rd_lane
);
  assign merged  = merge_lanes(old_dw, wdata, size, lo);
  assign rd_lane = pick_lane(rd_dw, size, lo);
endmodule

// File: rtl/cfg_xlate_ctrl.sv
module cfg_xlate_ctrl
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_fn,
  input  logic [OFS_W-1:0] req_ofs,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  output logic [BUS_W-1:0] lat_bus,
  output logic [DEV_W-1:0] lat_dev,
  output logic [FN_W-1:0]  lat_fn,
  output logic [OFS_W-1:0] lat_ofs,
  output logic [1:0]       lat_size,
  output logic             lat_write,
  output logic [DW-1:0]    lat_wdata,
  input  logic             tuple_ok,
  input  logic [DW-1:0]    rd_lane,
  output logic [DW-1:0]    hold_q,
  output logic             acc_valid,
  input  logic             acc_ready,
  output logic             acc_write,
  input  logic [DW-1:0]    acc_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_err,
  output logic             ev_filtered,
  output logic             ev_rmw_done
);
  state_e st_q;
  logic   sub_dw;

  assign sub_dw      = !lat_size[1];
  assign req_ready   = (st_q == ST_IDLE);
  assign acc_valid   = (st_q == ST_RMW) || (st_q == ST_ACC);
  assign acc_write   = (st_q == ST_ACC) && lat_write;
  assign rsp_valid   = (st_q == ST_RESP);
  assign ev_filtered = (st_q == ST_CHK) && !tuple_ok;
  assign ev_rmw_done = (st_q == ST_RMW) && acc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      lat_bus   <= '0;
      lat_dev   <= '0;
      lat_fn    <= '0;
      lat_ofs   <= '0;
      lat_size  <= '0;
      lat_write <= 1'b0;
      lat_wdata <= '0;
      hold_q    <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          lat_bus   <= req_bus;
          lat_dev   <= req_dev;
          lat_fn    <= req_fn;
          lat_ofs   <= req_ofs;
          lat_size  <= req_size;
          lat_write <= req_write;
          lat_wdata <= req_wdata;
          st_q      <= ST_CHK;
        end
        ST_CHK: begin
          if (!tuple_ok) begin
            rsp_rdata <= lat_write ? '0 : '1;
            rsp_err   <= lat_write;
            st_q      <= ST_RESP;
          end else if (lat_write && sub_dw) begin
            st_q <= ST_RMW;
          end else begin
            st_q <= ST_ACC;
          end
        end
        ST_RMW: if (acc_ready) begin
          hold_q <= acc_rdata;
          st_q   <= ST_ACC;
        end
        ST_ACC: if (acc_ready) begin
          rsp_rdata <= lat_write ? '0 : rd_lane;
          rsp_err   <= 1'b0;
          st_q      <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned DEV_W     = 5,
  parameter int unsigned FN_W      = 3,
  parameter int unsigned OFS_W     = 12,
  parameter int unsigned BUS0_DEVS = 2,
  parameter int unsigned BUS1_DEVS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_fn,
  input  logic [OFS_W-1:0] req_ofs,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic [31:0]      req_wdata,
  output logic             acc_valid,
  input  logic             acc_ready,
  output logic             acc_write,
  output logic             acc_remote,
  output logic [2:0]       acc_wtype,
  output logic [31:0]      acc_tgt,
  output logic [OFS_W-1:0] acc_addr,
  output logic [31:0]      acc_wdata,
  input  logic [31:0]      acc_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_err
);
  logic [BUS_W-1:0] lat_bus;
  logic [DEV_W-1:0] lat_dev;
  logic [FN_W-1:0]  lat_fn;
  logic [OFS_W-1:0] lat_ofs;
  logic [1:0]       lat_size;
  logic             lat_write;
  logic [DW-1:0]    lat_wdata;
  logic [DW-1:0]    hold_q;
  logic [DW-1:0]    merged;
  logic [DW-1:0]    rd_lane;
  logic             tuple_ok;
  logic             ev_filtered;
  logic             ev_rmw_done;

  cfg_xlate_ctrl #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFS_W(OFS_W)) u_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_bus, .req_dev, .req_fn, .req_ofs,
    .req_size, .req_write, .req_wdata,
    .lat_bus, .lat_dev, .lat_fn, .lat_ofs, .lat_size, .lat_write, .lat_wdata,
    .tuple_ok, .rd_lane, .hold_q,
    .acc_valid, .acc_ready, .acc_write, .acc_rdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_err,
    .ev_filtered, .ev_rmw_done
  );

  cfg_xlate_route #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFS_W(OFS_W),
    .BUS0_DEVS(BUS0_DEVS), .BUS1_DEVS(BUS1_DEVS)
  ) u_route (
    .bus(lat_bus), .dev(lat_dev), .fn(lat_fn), .ofs(lat_ofs),
    .tuple_ok, .remote(acc_remote), .wtype(acc_wtype), .tgt(acc_tgt), .addr(acc_addr)
  );

  cfg_xlate_lanes u_lanes (
    .old_dw(hold_q), .wdata(lat_wdata), .rd_dw(acc_rdata),
    .size(lat_size), .lo(lat_ofs[1:0]), .merged, .rd_lane
  );

  assign acc_wdata = !acc_write ? '0 : (lat_size[1] ? lat_wdata : merged);
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int unsigned OFS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             acc_write,
  input logic             acc_remote,
  input logic [2:0]       acc_wtype,
  input logic [31:0]      acc_tgt,
  input logic [OFS_W-1:0] acc_addr,
  input logic [31:0]      acc_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic             rsp_err,
  input logic             ev_filtered,
  input logic             ev_rmw_done
);
  // R11
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_write) && $stable(acc_addr)
                                && $stable(acc_wdata) && $stable(acc_tgt));
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
  // R11
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !acc_valid && !rsp_valid);
  // R7
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> acc_addr[1:0] == 2'b00);
  // R4
  local_notgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_remote |-> acc_tgt == 32'h0 && acc_wtype == 3'd4);
  // R5
  type1_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_wtype == 3'd5 |-> acc_remote);
  // R5
  wtype_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_wtype == 3'd4) || (acc_wtype == 3'd5));
  // R2
  filtered_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_filtered |=> !acc_valid && rsp_valid);
  // R8
  rmw_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rmw_done |=> acc_valid && acc_write);
  // R3
  err_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == 32'h0);
endmodule

bind cfg_xlate cfg_xlate_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
  .acc_remote(acc_remote), .acc_wtype(acc_wtype), .acc_tgt(acc_tgt),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .ev_filtered(ev_filtered), .ev_rmw_done(ev_rmw_done)
);

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_ofs = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        acc_valid;
  logic        acc_ready = 1'b0;
  logic        acc_write;
  logic        acc_remote;
  logic [2:0]  acc_wtype;
  logic [31:0] acc_tgt;
  logic [11:0] acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  always #2 clk = ~clk;

  cfg_xlate u_dut (.*);

  typedef struct {
    bit        wr;
    bit        remote;
    bit [2:0]  wtype;
    bit [31:0] tgt;
    bit [11:0] addr;
    bit [31:0] wdata;
  } exp_t;

  exp_t            expq[$];
  logic [31:0]     mem [bit [31:0]];
  int              n_cmp = 0;
  int              n_bad = 0;
  int              wait_left = 0;
  string           cur_tag = "R11";
  bit              ended = 0;

  function automatic logic [31:0] dflt(bit [31:0] k);
    return 32'hC3A5_0F1E ^ (k * 32'h0001_9E37) ^ {k[15:0], k[31:16]};
  endfunction

  function automatic logic [31:0] rd_model(bit [31:0] k);
    if (mem.exists(k)) return mem[k];
    return dflt(k);
  endfunction

  function automatic bit [31:0] mkkey(bit rem, bit [31:0] tgt, bit [11:0] a);
    return {3'b000, rem, tgt[31:16], a};
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // downstream target model, compared on every clock while an access is shown
  always @(negedge clk) begin
    if (rst_n) begin
      acc_ready = 1'b0;
      if (acc_valid) begin
        if (expq.size() == 0) begin
          check("R11 unexpected downstream access", 64'(acc_addr), 64'hFFFF);
        end else begin
          exp_t e;
          e = expq[0];
          check("R4/R5/R6/R7 access fields",
                {acc_write, acc_remote, acc_wtype, acc_tgt, acc_addr},
                {e.wr, e.remote, e.wtype, e.tgt, e.addr});
          if (e.wr) check("R8/R9 write dword", 64'(acc_wdata), 64'(e.wdata));
        end
        if (wait_left == 0) begin
          bit [31:0] k;
          k = mkkey(acc_remote, acc_tgt, acc_addr);
          acc_ready = 1'b1;
          acc_rdata = rd_model(k);
          if (acc_write) mem[k] = acc_wdata;
          if (expq.size() != 0) void'(expq.pop_front());
          wait_left = $urandom_range(0, 2);
        end else begin
          wait_left--;
        end
      end
    end
  end

  task automatic xact(string tag, bit [7:0] bus, bit [4:0] dev, bit [2:0] fn,
                      bit [11:0] ofs, bit [1:0] size, bit wr, bit [31:0] wd);
    bit        present, rem;
    bit [2:0]  wt;
    bit [31:0] tgt, cur, exp_rd, newdw;
    bit [11:0] a;
    bit        exp_err;
    int        first, cnt, hold;
    exp_t      e;
    cur_tag = tag;
    present = !((bus == 0 && dev > 1) || (bus == 1 && dev > 0));
    rem = (bus != 0);
    wt  = (bus < 2) ? 3'd4 : 3'd5;
    tgt = rem ? ((32'(bus) << 24) | (32'(dev) << 19) | (32'(fn) << 16)) : 32'h0;
    a   = ofs & 12'hFFC;
    cur = rd_model(mkkey(rem, tgt, a));
    first = (size == 0) ? int'(ofs[1:0]) : (size == 1) ? int'(ofs[1]) * 2 : 0;
    cnt   = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    exp_rd = 0;
    exp_err = 0;
    e.remote = rem; e.wtype = wt; e.tgt = tgt; e.addr = a;
    if (!present) begin
      exp_rd = wr ? 32'h0 : 32'hFFFF_FFFF;
      exp_err = wr;
    end else if (wr) begin
      if (cnt < 4) begin
        e.wr = 0; e.wdata = 0; expq.push_back(e);
        newdw = cur;
        for (int i = 0; i < cnt; i++) newdw[8*(first+i) +: 8] = wd[8*i +: 8];
      end else begin
        newdw = wd;
      end
      e.wr = 1; e.wdata = newdw; expq.push_back(e);
    end else begin
      e.wr = 0; e.wdata = 0; expq.push_back(e);
      for (int i = 0; i < cnt; i++) exp_rd[8*i +: 8] = cur[8*(first+i) +: 8];
    end
    @(negedge clk);
    req_bus = bus; req_dev = dev; req_fn = fn; req_ofs = ofs;
    req_size = size; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 busy drops ready", 64'(req_ready), 64'h0);
    while (!rsp_valid) @(negedge clk);
    hold = $urandom_range(0, 2);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R11 response held", 64'(rsp_valid), 64'h1);
    end
    check("response data", 64'(rsp_rdata), 64'(exp_rd));
    check("response err", 64'(rsp_err), 64'(exp_err));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R2/R3 access count", 64'(expq.size()), 64'h0);
    expq.delete();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "R11 reset";
    check("reset state", {req_ready, acc_valid, rsp_valid}, 3'b100);

    // R1 / R2: absent tuples read as all ones, no access
    xact("R1 R2 bus0 dev2 read", 8'd0, 5'd2, 3'd0, 12'h000, 2'd2, 0, 0);
    xact("R1 R2 bus1 dev1 read", 8'd1, 5'd1, 3'd0, 12'h010, 2'd0, 0, 0);
    xact("R1 R2 bus0 dev31 half read", 8'd0, 5'd31, 3'd7, 12'h102, 2'd1, 0, 0);
    // R3: absent write rejected
    xact("R3 bus0 dev5 write", 8'd0, 5'd5, 3'd1, 12'h004, 2'd2, 1, 32'h1234_5678);
    xact("R3 bus1 dev3 byte write", 8'd1, 5'd3, 3'd0, 12'h005, 2'd0, 1, 32'hAB);
    // R4 R9: local dword write/read on both present bus0 devices
    xact("R4 R9 bus0 dev0 write", 8'd0, 5'd0, 3'd0, 12'h040, 2'd2, 1, 32'hDEAD_BEEF);
    xact("R4 R9 bus0 dev0 read", 8'd0, 5'd0, 3'd0, 12'h040, 2'd3, 0, 0);
    xact("R1 R4 bus0 dev1 read", 8'd0, 5'd1, 3'd2, 12'h008, 2'd2, 0, 0);
    // R5 R6: remote type 0 and type 1
    xact("R5 R6 bus1 dev0 fn7 read", 8'd1, 5'd0, 3'd7, 12'h0FC, 2'd2, 0, 0);
    xact("R5 R6 bus2 write", 8'd2, 5'd17, 3'd3, 12'h018, 2'd2, 1, 32'h00FF_0102);
    xact("R5 R6 bus2 readback", 8'd2, 5'd17, 3'd3, 12'h018, 2'd2, 0, 0);
    xact("R5 R6 bus255 dev31", 8'd255, 5'd31, 3'd5, 12'hFFC, 2'd2, 0, 0);
    // R7: unaligned offset for a dword access
    xact("R7 low bits cleared", 8'd3, 5'd4, 3'd0, 12'h023, 2'd2, 0, 0);
    // R8: byte writes into every lane, halfwords at odd offsets, then readback
    xact("R8 seed dword", 8'd4, 5'd1, 3'd1, 12'h080, 2'd2, 1, 32'h1122_3344);
    for (int l = 0; l < 4; l++)
      xact("R8 byte lane write", 8'd4, 5'd1, 3'd1, 12'h080 + 12'(l), 2'd0, 1,
           32'hFFFF_FF00 | 32'(8'hA0 + l));
    xact("R9 R8 readback bytes", 8'd4, 5'd1, 3'd1, 12'h080, 2'd2, 0, 0);
    xact("R8 half lane hi at ofs3", 8'd4, 5'd1, 3'd1, 12'h083, 2'd1, 1, 32'hFFFF_5A6B);
    xact("R8 half lane lo at ofs1", 8'd0, 5'd0, 3'd0, 12'h041, 2'd1, 1, 32'h0000_C0DE);
    xact("R9 R8 readback halves", 8'd4, 5'd1, 3'd1, 12'h080, 2'd2, 0, 0);
    xact("R9 R8 local readback", 8'd0, 5'd0, 3'd0, 12'h040, 2'd2, 0, 0);
    // R10: sub-dword reads zero-extend the lane
    xact("R10 byte read lane2", 8'd4, 5'd1, 3'd1, 12'h082, 2'd0, 0, 0);
    xact("R10 byte read lane3", 8'd0, 5'd0, 3'd0, 12'h043, 2'd0, 0, 0);
    xact("R10 half read ofs3", 8'd4, 5'd1, 3'd1, 12'h083, 2'd1, 0, 0);
    xact("R10 half read ofs0", 8'd2, 5'd17, 3'd3, 12'h018, 2'd1, 0, 0);
    // mixed traffic over a small address pool
    for (int n = 0; n < 300; n++) begin
      bit [7:0] b;
      b = 8'($urandom_range(0, 3));
      xact("R1 R8 R10 mixed", b, 5'($urandom_range(0, 2)), 3'($urandom_range(0, 1)),
           12'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           $urandom());
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule